// File: doc/BRIEF.md
# Indirect Subsystem Register Bridge

This block lets a host reach a byte-wide register space inside a slow subsystem without mapping that space directly. The host sees six 32-bit registers: a fixed identification word, a command register, two data words, an interrupt enable register and an interrupt flag register. The command register holds the target subsystem address, a direction bit and byte-lane enables. When the command register is written with the direction bit set, the bridge launches a read. When the direction bit is clear, the launch waits for a write to the lower data word. In both cases the bridge drives a one-cycle request on a synchronous byte port. It then reports busy for a fixed number of cycles.

A read result lands in the lower data word, in the byte lane picked by the enables. Two interrupt sources feed a small write-one-to-clear flag register: the end of every subsystem access, and rising edges of the subsystem's interrupt line. A masked OR of the flags drives the host interrupt pin. Host reads are registered and return one cycle after the address is presented. Host writes are single-cycle strobes.

Top module: `sub_reg_bridge`

## Requirements
- R1: After reset the identification word (offset 0x00) reads `ID_VALUE`. The command (0x04), lower data (0x08), upper data (0x0C), enable (0x10) and flag (0x14) registers read zero. `sub_req` and `host_irq` are low.
- R2: Reading the command register returns the subsystem address in bits 7:0, the lower byte enables in bits 19:16, the upper byte enables in bits 23:20, the direction in bit 24 and the size bit in bit 25, all as last written. Bit 31 is the busy flag. All other bits read zero.
- R3: A command write with bit 24 = 1 and at least one of bits 19:16 set, accepted while idle, issues exactly one cycle of `sub_req` with `sub_we` = 0 and `sub_addr` equal to bits 7:0 of the written word.
- R4: A lower-data write accepted while idle, when the stored direction is 0 and at least one stored enable in bits 19:16 is set, issues one cycle of `sub_req` with `sub_we` = 1. `sub_addr` is the stored address. `sub_wdata` is the byte lane of the written word chosen by the lowest set enable: bit 16 selects bits 7:0, bit 17 selects 15:8, bit 18 selects 23:16 and bit 19 selects 31:24.
- R5: Bit 31 of the command register reads 1 for exactly `BUSY_CYCLES` consecutive register reads after a launch.
- R6: When a read finishes, the lower data word holds the returned byte in the lane chosen by the lowest set enable, with all other bits zero.
- R7: No subsystem request is issued when all of the enables in bits 19:16 are zero, or on a lower-data write while the stored direction is 1.
- R8: Writes to the command, lower data and upper data registers while busy is set are dropped and issue no request.
- R9: Flag bit 0 sets when an access finishes. Flag bit 1 sets on a rising edge of `sub_irq`; a level held high does not set it again after it is cleared.
- R10: Writing 1 to a flag bit clears it. If that bit's set event falls in the same cycle as the clear, the bit stays set.
- R11: `host_irq` goes high one cycle after any flag bit and its matching enable bit (same bit position in the register at 0x10) are both 1, and stays low while no enabled flag is set.
- R12: The upper data word is plain 32-bit storage that reads back the last accepted write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_we | input | 1 | Host write strobe, one cycle per write |
| host_addr | input | 5 | Host byte offset of the register |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Registered read data for the previous cycle's address |
| host_irq | output | 1 | Masked interrupt request to the host |
| sub_req | output | 1 | One-cycle subsystem access request |
| sub_we | output | 1 | Subsystem access is a write |
| sub_addr | output | 8 | Subsystem register address |
| sub_wdata | output | 8 | Subsystem write byte |
| sub_rdata | input | 8 | Subsystem read byte, valid before the access ends |
| sub_irq | input | 1 | Subsystem interrupt level |

## Verification
Two pairs of events can land in the same clock edge. A set event can meet a write-one-to-clear of the same flag bit, and an access can finish in the same cycle that software clears its completion flag. The bench times a clear write to hit the exact edge where `sub_irq` first rises. It also times a clear to hit the final edge of a read's busy window. In both cases it judges from the flag register read afterwards that the bit is still set. A scoreboard queue of expected subsystem requests also shows that writes dropped during busy never reach the subsystem port.

// File: rtl/sbr_pkg.sv
package sbr_pkg;
  localparam int HOST_AW = 5;
  localparam int HOST_DW = 32;
  localparam int SUB_AW  = 8;
  localparam int SUB_DW  = 8;
  localparam int LANES   = HOST_DW / SUB_DW;
  localparam int LANE_W  = $clog2(LANES);

  localparam logic [HOST_AW-1:0] OFF_ID    = 5'h00;
  localparam logic [HOST_AW-1:0] OFF_CMD   = 5'h04;
  localparam logic [HOST_AW-1:0] OFF_LDATA = 5'h08;
  localparam logic [HOST_AW-1:0] OFF_UDATA = 5'h0C;
  localparam logic [HOST_AW-1:0] OFF_IEN   = 5'h10;
  localparam logic [HOST_AW-1:0] OFF_IFLG  = 5'h14;

  localparam int BIT_BUSY = 31;
  localparam int BIT_SIZE = 25;
  localparam int BIT_DIR  = 24;
  localparam int BEL_LO   = 16;

  // Lowest set enable picks the byte lane.
  function automatic logic [LANE_W-1:0] lane_of(input logic [LANES-1:0] be);
    logic [LANE_W-1:0] idx;
    idx = '0;
    for (int i = LANES - 1; i >= 0; i--) begin
      if (be[i]) idx = LANE_W'(i);
    end
    return idx;
  endfunction
endpackage

// File: rtl/sbr_access_seq.sv
module sbr_access_seq
  import sbr_pkg::*;
#(
  parameter int BUSY_CYCLES = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              launch,
  input  logic              launch_we,
  input  logic [SUB_AW-1:0] launch_addr,
  input  logic [SUB_DW-1:0] launch_data,
  output logic              busy,
  output logic              finish,
  output logic              sub_req,
  output logic              sub_we,
  output logic [SUB_AW-1:0] sub_addr,
  output logic [SUB_DW-1:0] sub_wdata
);
  localparam int CNT_W = $clog2(BUSY_CYCLES + 1);

  logic [CNT_W-1:0] cnt_q;

  assign busy   = (cnt_q != '0);
  assign finish = (cnt_q == CNT_W'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q     <= '0;
      sub_req   <= 1'b0;
      sub_we    <= 1'b0;
      sub_addr  <= '0;
      sub_wdata <= '0;
    end else begin
      sub_req <= launch;
      if (launch) begin
        cnt_q     <= CNT_W'(BUSY_CYCLES);
        sub_we    <= launch_we;
        sub_addr  <= launch_addr;
        sub_wdata <= launch_data;
      end else if (busy) begin
        cnt_q <= cnt_q - CNT_W'(1);
      end
    end
  end

  // R3 / R4: a request lasts a single cycle
  a_r3_req_single: assert property (@(posedge clk) disable iff (rst)
    sub_req |=> !sub_req);
  // R5: a request always sits inside the busy window
  a_r5_req_in_busy: assert property (@(posedge clk) disable iff (rst)
    sub_req |-> busy);
endmodule

// File: rtl/sbr_irq_ctrl.sv
module sbr_irq_ctrl #(
  parameter int NSRC = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            sub_irq,
  input  logic            done_evt,
  input  logic            en_we,
  input  logic            clr_we,
  input  logic [NSRC-1:0] wdata,
  output logic [NSRC-1:0] en_q,
  output logic [NSRC-1:0] flag_q,
  output logic            host_irq
);
  logic            irq_prev_q;
  logic [NSRC-1:0] set_evt;

  always_comb begin
    set_evt    = '0;
    set_evt[0] = done_evt;
    set_evt[1] = sub_irq & ~irq_prev_q;
  end

  generate
    for (genvar i = 0; i < NSRC; i++) begin : g_flag
      always_ff @(posedge clk) begin
        if (rst) flag_q[i] <= 1'b0;
        else     flag_q[i] <= set_evt[i] | (flag_q[i] & ~(clr_we & wdata[i]));
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_prev_q <= 1'b0;
      en_q       <= '0;
      host_irq   <= 1'b0;
    end else begin
      irq_prev_q <= sub_irq;
      if (en_we) en_q <= wdata;
      host_irq <= |(flag_q & en_q);
    end
  end

  // R9: completion raises flag bit 0
  a_r9_done_flag: assert property (@(posedge clk) disable iff (rst)
    done_evt |=> flag_q[0]);
  // R9: a rising subsystem interrupt raises flag bit 1
  a_r9_edge_flag: assert property (@(posedge clk) disable iff (rst)
    (sub_irq && !irq_prev_q) |=> flag_q[1]);
  // R11: host interrupt low when nothing enabled was pending
  a_r11_irq_quiet: assert property (@(posedge clk) disable iff (rst)
    ((flag_q & en_q) == '0) |=> !host_irq);
endmodule

// File: rtl/sub_reg_bridge.sv
module sub_reg_bridge
  import sbr_pkg::*;
#(
  parameter int          BUSY_CYCLES = 4,
  parameter logic [31:0] ID_VALUE    = 32'h5B10_0001
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               host_we,
  input  logic [HOST_AW-1:0] host_addr,
  input  logic [HOST_DW-1:0] host_wdata,
  output logic [HOST_DW-1:0] host_rdata,
  output logic               host_irq,
  output logic               sub_req,
  output logic               sub_we,
  output logic [SUB_AW-1:0]  sub_addr,
  output logic [SUB_DW-1:0]  sub_wdata,
  input  logic [SUB_DW-1:0]  sub_rdata,
  input  logic               sub_irq
);
  logic [SUB_AW-1:0]    cmd_addr_q;
  logic [2*LANES-1:0]   cmd_be_q;
  logic                 cmd_dir_q;
  logic                 cmd_size_q;
  logic [HOST_DW-1:0]   ldata_q;
  logic [HOST_DW-1:0]   udata_q;
  logic                 busy;
  logic                 finish;
  logic [1:0]           ien_q;
  logic [1:0]           iflg_q;

  logic wr_cmd, wr_ldata, wr_udata, wr_ien, wr_iflg;
  logic launch_rd, launch_wr, launch;
  logic [SUB_AW-1:0] launch_addr;
  logic [SUB_DW-1:0] launch_data;
  logic [LANE_W-1:0] wr_lane;
  logic [HOST_DW-1:0] cmd_view;

  assign wr_cmd   = host_we && (host_addr == OFF_CMD);
  assign wr_ldata = host_we && (host_addr == OFF_LDATA);
  assign wr_udata = host_we && (host_addr == OFF_UDATA);
  assign wr_ien   = host_we && (host_addr == OFF_IEN);
  assign wr_iflg  = host_wdata[0] | host_wdata[1] ? host_we && (host_addr == OFF_IFLG) : 1'b0;

  assign launch_rd = wr_cmd && !busy && host_wdata[BIT_DIR]
                     && (host_wdata[BEL_LO +: LANES] != '0);
  assign launch_wr = wr_ldata && !busy && !cmd_dir_q && (cmd_be_q[LANES-1:0] != '0);
  assign launch    = launch_rd || launch_wr;

  assign wr_lane     = lane_of(cmd_be_q[LANES-1:0]);
  assign launch_addr = launch_rd ? host_wdata[SUB_AW-1:0] : cmd_addr_q;
  assign launch_data = host_wdata[wr_lane*SUB_DW +: SUB_DW];

  always_ff @(posedge clk) begin
    if (rst) begin
      cmd_addr_q <= '0;
      cmd_be_q   <= '0;
      cmd_dir_q  <= 1'b0;
      cmd_size_q <= 1'b0;
      ldata_q    <= '0;
      udata_q    <= '0;
    end else begin
      if (wr_cmd && !busy) begin
        cmd_addr_q <= host_wdata[SUB_AW-1:0];
        cmd_be_q   <= host_wdata[BEL_LO +: 2*LANES];
        cmd_dir_q  <= host_wdata[BIT_DIR];
        cmd_size_q <= host_wdata[BIT_SIZE];
      end
      if (finish && !sub_we) begin
        ldata_q <= '0;
        ldata_q[wr_lane*SUB_DW +: SUB_DW] <= sub_rdata;
      end else if (wr_ldata && !busy) begin
        ldata_q <= host_wdata;
      end
      if (wr_udata && !busy) udata_q <= host_wdata;
    end
  end

  always_comb begin
    cmd_view = '0;
    cmd_view[BIT_BUSY]               = busy;
    cmd_view[BIT_SIZE]               = cmd_size_q;
    cmd_view[BIT_DIR]                = cmd_dir_q;
    cmd_view[BEL_LO +: 2*LANES]      = cmd_be_q;
    cmd_view[SUB_AW-1:0]             = cmd_addr_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      host_rdata <= '0;
    end else begin
      case (host_addr)
        OFF_ID:    host_rdata <= ID_VALUE;
        OFF_CMD:   host_rdata <= cmd_view;
        OFF_LDATA: host_rdata <= ldata_q;
        OFF_UDATA: host_rdata <= udata_q;
        OFF_IEN:   host_rdata <= {30'd0, ien_q};
        OFF_IFLG:  host_rdata <= {30'd0, iflg_q};
        default:   host_rdata <= '0;
      endcase
    end
  end

  sbr_access_seq #(.BUSY_CYCLES(BUSY_CYCLES)) u_seq (
    .clk         (clk),
    .rst         (rst),
    .launch      (launch),
    .launch_we   (launch_wr),
    .launch_addr (launch_addr),
    .launch_data (launch_data),
    .busy        (busy),
    .finish      (finish),
    .sub_req     (sub_req),
    .sub_we      (sub_we),
    .sub_addr    (sub_addr),
    .sub_wdata   (sub_wdata)
  );

  sbr_irq_ctrl #(.NSRC(2)) u_irq (
    .clk      (clk),
    .rst      (rst),
    .sub_irq  (sub_irq),
    .done_evt (finish),
    .en_we    (wr_ien),
    .clr_we   (wr_iflg),
    .wdata    (host_wdata[1:0]),
    .en_q     (ien_q),
    .flag_q   (iflg_q),
    .host_irq (host_irq)
  );

  // R8: lower data holds still through a busy window
  a_r8_ldata_hold: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy)) |-> $stable(ldata_q));
  // R8: command fields cannot change while busy
  a_r8_cmd_hold: assert property (@(posedge clk) disable iff (rst)
    busy |=> ($stable(cmd_addr_q) && $stable(cmd_be_q) && $stable(cmd_dir_q)));
  // R7: no request without a lower enable
  a_r7_need_enable: assert property (@(posedge clk) disable iff (rst)
    (sub_req && sub_we) |-> (cmd_be_q[LANES-1:0] != '0));
endmodule

// File: tb/sub_reg_bridge_tb.sv
module sub_reg_bridge_tb;
  localparam int NB = 4;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        host_we = 1'b0;
  logic [4:0]  host_addr = '0;
  logic [31:0] host_wdata = '0;
  logic [31:0] host_rdata;
  logic        host_irq;
  logic        sub_req, sub_we;
  logic [7:0]  sub_addr, sub_wdata;
  logic [7:0]  sub_rdata;
  logic        sub_irq = 1'b0;

  int errors = 0;
  int checks = 0;
  bit finished = 1'b0;

  typedef struct packed { logic we; logic [7:0] addr; logic [7:0] data; } txn_t;
  txn_t exp_q[$];

  logic [7:0] mem [256];
  logic [7:0] rd_q = '0;
  assign sub_rdata = rd_q;

  always #4 clk = ~clk;

  sub_reg_bridge #(.BUSY_CYCLES(NB)) u_dut (
    .clk(clk), .rst(rst), .host_we(host_we), .host_addr(host_addr),
    .host_wdata(host_wdata), .host_rdata(host_rdata), .host_irq(host_irq),
    .sub_req(sub_req), .sub_we(sub_we), .sub_addr(sub_addr),
    .sub_wdata(sub_wdata), .sub_rdata(sub_rdata), .sub_irq(sub_irq)
  );

  initial for (int i = 0; i < 256; i++) mem[i] = 8'(i) ^ 8'hA5;

  // subsystem model
  always @(posedge clk) begin
    if (sub_req) begin
      if (sub_we) mem[sub_addr] <= sub_wdata;
      else        rd_q <= mem[sub_addr];
    end
  end

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, got, exp);
    end
  endtask

  // scoreboard monitor (R3, R4, R7, R8)
  always @(negedge clk) begin
    if (!rst && sub_req) begin
      checks++;
      if (exp_q.size() == 0) begin
        errors++;
        $display("FAIL R7/R8 unexpected request: actual=%h expected=none",
                 {sub_we, sub_addr, sub_wdata});
      end else begin
        txn_t e;
        e = exp_q.pop_front();
        if (sub_we !== e.we || sub_addr !== e.addr || (e.we && sub_wdata !== e.data)) begin
          errors++;
          $display("FAIL R3/R4 request: actual=%h expected=%h",
                   {sub_we, sub_addr, sub_wdata}, e);
        end
      end
    end
  end

  // all tasks start and end at a negedge
  task automatic hwr(input logic [4:0] a, input logic [31:0] d);
    host_addr = a; host_wdata = d; host_we = 1'b1;
    @(negedge clk);
    host_we = 1'b0;
  endtask

  task automatic hrd(input logic [4:0] a, output logic [31:0] d);
    host_addr = a;
    @(negedge clk);
    d = host_rdata;
  endtask

  task automatic wait_idle();
    logic [31:0] v;
    for (int i = 0; i < 50; i++) begin
      hrd(5'h04, v);
      if (!v[31]) break;
    end
    @(negedge clk);
  endtask

  initial begin
    logic [31:0] v;
    int cnt;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1 reset state
    hrd(5'h00, v); check("R1 id", v, 32'h5B10_0001);
    hrd(5'h04, v); check("R1 cmd", v, 0);
    hrd(5'h08, v); check("R1 ldata", v, 0);
    hrd(5'h0C, v); check("R1 udata", v, 0);
    hrd(5'h10, v); check("R1 ien", v, 0);
    hrd(5'h14, v); check("R1 iflg", v, 0);
    check("R1 irq", {31'd0, host_irq}, 0);

    // R12 upper data storage
    hwr(5'h0C, 32'hCAFE_F00D);
    hrd(5'h0C, v); check("R12 udata", v, 32'hCAFE_F00D);

    // R2 field readback, direction 0 so no launch
    hwr(5'h04, 32'hFEF0_FF5A);
    hrd(5'h04, v); check("R2 cmd view", v, 32'h02F0_005A);
    // R7 lower-data write with no lower enables: stored, no request
    hwr(5'h08, 32'h1234_5678);
    repeat (NB + 1) @(negedge clk);
    hrd(5'h08, v); check("R7 ldata stored", v, 32'h1234_5678);
    // R7 read command with no lower enables
    hwr(5'h04, 32'h0100_0040);
    repeat (NB + 1) @(negedge clk);
    hrd(5'h04, v); check("R7 no busy", v, 32'h0100_0040);
    // R7 lower-data write while direction is read
    hwr(5'h04, 32'h0100_0000);
    hwr(5'h08, 32'h0000_0011);
    repeat (NB + 1) @(negedge clk);

    // R4 write via lane 1, R5 busy length
    hwr(5'h04, 32'h0002_0033);
    exp_q.push_back('{1'b1, 8'h33, 8'h33});
    hwr(5'h08, 32'h1122_3344);
    host_addr = 5'h04;
    cnt = 0;
    for (int i = 0; i < 3 * NB; i++) begin
      @(negedge clk);
      if (host_rdata[31]) cnt++;
    end
    check("R5 busy cycles", cnt, NB);
    hrd(5'h14, v); check("R9 done flag", v & 1, 1);
    hwr(5'h14, 32'h3);
    hrd(5'h14, v); check("R10 w1c", v, 0);

    // R3 / R6 read back through lane 2
    exp_q.push_back('{1'b0, 8'h33, 8'h00});
    hwr(5'h04, 32'h0104_0033);
    wait_idle();
    hrd(5'h08, v); check("R6 lane2 read", v, 32'h0033_0000);
    exp_q.push_back('{1'b0, 8'h80, 8'h00});
    hwr(5'h04, 32'h010F_0080);
    wait_idle();
    hrd(5'h08, v); check("R6 lane0 read", v, 32'h0000_0025);

    // R8 writes during busy are dropped
    exp_q.push_back('{1'b0, 8'h10, 8'h00});
    hwr(5'h04, 32'h0108_0010);
    hwr(5'h04, 32'h0001_0099);
    hwr(5'h08, 32'hDEAD_BEEF);
    hwr(5'h0C, 32'h0BAD_0BAD);
    wait_idle();
    hrd(5'h04, v); check("R8 cmd kept", v, 32'h0108_0010);
    hrd(5'h08, v); check("R8 ldata from read", v, 32'hB500_0000);
    hrd(5'h0C, v); check("R8 udata kept", v, 32'hCAFE_F00D);

    // R9 / R11 subsystem interrupt
    hwr(5'h14, 32'h3);
    hwr(5'h10, 32'h1);
    sub_irq = 1'b1;
    @(negedge clk); @(negedge clk);
    hrd(5'h14, v); check("R9 edge flag", v, 2);
    check("R11 masked irq", {31'd0, host_irq}, 0);
    hwr(5'h10, 32'h3);
    @(negedge clk);
    check("R11 irq high", {31'd0, host_irq}, 1);
    hwr(5'h14, 32'h2);
    @(negedge clk); @(negedge clk);
    hrd(5'h14, v); check("R9 level no reset", v, 0);
    check("R11 irq low", {31'd0, host_irq}, 0);
    sub_irq = 1'b0;
    @(negedge clk);
    // set flag1, then clear it in the same edge as a new rise
    sub_irq = 1'b1; @(negedge clk); sub_irq = 1'b0; @(negedge clk);
    sub_irq = 1'b1;
    hwr(5'h14, 32'h2);
    hrd(5'h14, v); check("R10 set wins flag1", v, 2);
    sub_irq = 1'b0;

    // R10 completion in the same edge as clearing flag0
    hwr(5'h14, 32'h3);
    exp_q.push_back('{1'b0, 8'h05, 8'h00});
    hwr(5'h04, 32'h0101_0005);
    repeat (NB - 1) @(negedge clk);
    hwr(5'h14, 32'h1);
    hrd(5'h14, v); check("R10 set wins flag0", v, 1);
    hrd(5'h08, v); check("R6 read addr5", v, 32'h0000_00A0);

    repeat (4) @(negedge clk);
    check("R3 queue drained", exp_q.size(), 0);
    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule